// File: doc/BRIEF.md
# Single-Bit Stored-Program Control Core

This block is a one-bit processing core for relay-style control. On every clock edge it samples a 4-bit opcode and a one-bit data line, and it executes that opcode in the same cycle. The program counter, program memory, input selector and output latches are outside the core. The core holds three one-bit registers: an accumulator (the result register), an input gate and an output gate. Control flow leaves the core only as single-cycle pulses for jump, return and the two no-op opcodes. The one exception is the skip of the next opcode, which a small internal flip-flop handles.

All outputs are registered. The effect of an opcode sampled at edge N appears on the ports between edge N and edge N+1. The tri-state data pin is modelled as a value (`dat_o`) and a drive enable (`dat_oe`). While the enable is low, `dat_o` is held at 0.

Top module: `bitctl_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, `acc_o`, `dat_o`, `dat_oe`, `wr_stb` and all four pulse outputs are 0. Reset also clears both gates and any pending skip. After reset, a load-complement of data 1 therefore gives `acc_o`=1, a store gives no strobe, and the first opcode is executed.
- R2: The core executes exactly one opcode per clock. Opcode 1 (load) puts the gated data bit into the accumulator. Opcode 2 (load complement) puts in its inverse. The new value shows on `acc_o` after the sampling edge.
- R3: Opcode 3 gives acc AND d and opcode 4 gives acc AND NOT d. Opcode 5 gives acc OR d and opcode 6 gives acc OR NOT d. Opcode 7 gives 1 when acc equals d and 0 otherwise. Here d is the gated data bit.
- R4: When the input gate is 0, every load and logic opcode (1 to 7) sees the data bit as 0.
- R5: With the output gate at 1, opcode 8 drives `dat_o`=acc and opcode 9 drives `dat_o`=NOT acc. Each holds `dat_oe`=1 and `wr_stb`=1 for the one following cycle, and the accumulator does not change.
- R6: With the output gate at 0, opcodes 8 and 9 leave `wr_stb` and `dat_oe` at 0.
- R7: Opcode A loads the raw data bit into the input gate and opcode B loads it into the output gate. Neither changes the accumulator.
- R8: Opcode 0 pulses `nop_lo_pulse`, opcode F pulses `nop_hi_pulse` and opcode C pulses `jump_pulse`, each for one cycle. None of them changes the accumulator or either gate. In any cycle, at most one of the four pulses and `wr_stb` is high.
- R9: Opcode D pulses `ret_pulse` for one cycle, and the opcode sampled on the next edge is skipped.
- R10: Opcode E skips the next opcode when the accumulator is 0. When the accumulator is 1, the next opcode executes normally.
- R11: A skipped opcode changes no register, raises no pulse and no strobe, and sets no further skip. The opcode after it executes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Opcode sampled on each edge |
| dat_i | input | 1 | Data line input |
| acc_o | output | 1 | Accumulator (result register) |
| dat_o | output | 1 | Stored data value, 0 when not driven |
| dat_oe | output | 1 | Drive enable for the data line |
| wr_stb | output | 1 | Write strobe, one cycle per executed store |
| jump_pulse | output | 1 | One-cycle pulse for opcode C |
| ret_pulse | output | 1 | One-cycle pulse for opcode D |
| nop_lo_pulse | output | 1 | One-cycle pulse for opcode 0 |
| nop_hi_pulse | output | 1 | One-cycle pulse for opcode F |

## Verification
The core is swept over every opcode, paired with every accumulator start value, both data values and all four settings of the input and output gates.

- The accumulator values tell apart the five combining functions and the two loads.
- The input-gate setting shows whether the gating applies to the load and logic opcodes and not to opcodes A and B.
- The output-gate setting separates a driven store from a suppressed one.

Each swept opcode is followed by opcode F. That pulse appears or stays away, which exposes whether a skip was armed, for return and for skip-if-zero with either accumulator value.

Further sequences cover these cases:
- a skip whose target is itself a return or a skip-if-zero;
- back-to-back stores;
- a reset applied while a skip is pending.

// File: rtl/bitctl_pkg.sv
package bitctl_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP_LO = 4'h0, OP_LOAD  = 4'h1, OP_LOADN = 4'h2, OP_AND  = 4'h3,
    OP_ANDN   = 4'h4, OP_OR    = 4'h5, OP_ORN   = 4'h6, OP_EQV  = 4'h7,
    OP_PUT    = 4'h8, OP_PUTN  = 4'h9, OP_IGATE = 4'hA, OP_OGATE = 4'hB,
    OP_JUMP   = 4'hC, OP_RET   = 4'hD, OP_SKZ   = 4'hE, OP_NOP_HI = 4'hF
  } bop_e;

  typedef struct packed {
    logic acc_wr;
    logic put;
    logic put_inv;
    logic ig_ld;
    logic og_ld;
    logic jump;
    logic ret;
    logic nop_lo;
    logic nop_hi;
    logic skz;
  } bctl_s;

  // Next accumulator value for load and logic opcodes; d is already gated.
  function automatic logic acc_next(bop_e op, logic acc, logic d);
    logic r;
    case (op)
      OP_LOAD:  r = d;
      OP_LOADN: r = ~d;
      OP_AND:   r = acc & d;
      OP_ANDN:  r = acc & ~d;
      OP_OR:    r = acc | d;
      OP_ORN:   r = acc | ~d;
      OP_EQV:   r = ~(acc ^ d);
      default:  r = acc;
    endcase
    return r;
  endfunction

  function automatic bctl_s decode(bop_e op);
    bctl_s c;
    c = '0;
    case (op)
      OP_LOAD, OP_LOADN, OP_AND, OP_ANDN,
      OP_OR, OP_ORN, OP_EQV: c.acc_wr = 1'b1;
      OP_PUT:    c.put = 1'b1;
      OP_PUTN:   begin c.put = 1'b1; c.put_inv = 1'b1; end
      OP_IGATE:  c.ig_ld = 1'b1;
      OP_OGATE:  c.og_ld = 1'b1;
      OP_JUMP:   c.jump = 1'b1;
      OP_RET:    c.ret = 1'b1;
      OP_SKZ:    c.skz = 1'b1;
      OP_NOP_LO: c.nop_lo = 1'b1;
      default:   c.nop_hi = 1'b1;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/bitctl_decode.sv
module bitctl_decode
  import bitctl_pkg::*;
(
  input  logic [OPW-1:0] op_raw,
  input  logic           squash,
  output bop_e           op,
  output bctl_s          ctl
);
  assign op  = bop_e'(op_raw);
  // A squashed (skipped) opcode decodes to no action at all.
  assign ctl = squash ? bctl_s'('0) : decode(op);
endmodule

// File: rtl/bitctl_regs.sv
module bitctl_regs
  import bitctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  bop_e op,
  input  logic acc_wr,
  input  logic ig_ld,
  input  logic og_ld,
  input  logic din,
  output logic acc_q,
  output logic ig_q,
  output logic og_q
);
  logic d_gated;
  assign d_gated = din & ig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= 1'b0;
      ig_q  <= 1'b0;
      og_q  <= 1'b0;
    end else begin
      if (acc_wr) acc_q <= acc_next(op, acc_q, d_gated);
      if (ig_ld)  ig_q  <= din;
      if (og_ld)  og_q  <= din;
    end
  end

  // A closed input gate makes a load see 0.
  assert_gate_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_wr && !ig_q && op == OP_LOAD) |-> !acc_q);
  // Gate-load opcodes never touch the accumulator.
  assert_gate_keep_acc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ig_ld || og_ld) |-> acc_q == $past(acc_q));
endmodule

// File: rtl/bitctl_seq.sv
module bitctl_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic put,
  input  logic put_inv,
  input  logic jump,
  input  logic ret,
  input  logic nop_lo,
  input  logic nop_hi,
  input  logic skz,
  input  logic acc,
  input  logic og,
  output logic skip_q,
  output logic dat_q,
  output logic oe_q,
  output logic wr_q,
  output logic jump_q,
  output logic ret_q,
  output logic nlo_q,
  output logic nhi_q
);
  logic put_go;
  assign put_go = put & og;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= 1'b0;
      dat_q  <= 1'b0;
      oe_q   <= 1'b0;
      wr_q   <= 1'b0;
      jump_q <= 1'b0;
      ret_q  <= 1'b0;
      nlo_q  <= 1'b0;
      nhi_q  <= 1'b0;
    end else begin
      skip_q <= ret | (skz & ~acc);
      dat_q  <= put_go & (acc ^ put_inv);
      oe_q   <= put_go;
      wr_q   <= put_go;
      jump_q <= jump;
      ret_q  <= ret;
      nlo_q  <= nop_lo;
      nhi_q  <= nop_hi;
    end
  end

  assert_write_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_q |-> $past(og));
  assert_skz_arms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(skz && !acc) |-> skip_q);
endmodule

// File: rtl/bitctl_core.sv
module bitctl_core
  import bitctl_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] op_i,
  input  logic           dat_i,
  output logic           acc_o,
  output logic           dat_o,
  output logic           dat_oe,
  output logic           wr_stb,
  output logic           jump_pulse,
  output logic           ret_pulse,
  output logic           nop_lo_pulse,
  output logic           nop_hi_pulse
);
  bop_e  op;
  bctl_s ctl;
  logic  skip_q, ig_q, og_q;

  bitctl_decode u_dec (.op_raw(op_i), .squash(skip_q), .op(op), .ctl(ctl));

  bitctl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .op(op), .acc_wr(ctl.acc_wr),
    .ig_ld(ctl.ig_ld), .og_ld(ctl.og_ld), .din(dat_i),
    .acc_q(acc_o), .ig_q(ig_q), .og_q(og_q)
  );

  bitctl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .put(ctl.put), .put_inv(ctl.put_inv),
    .jump(ctl.jump), .ret(ctl.ret), .nop_lo(ctl.nop_lo), .nop_hi(ctl.nop_hi),
    .skz(ctl.skz), .acc(acc_o), .og(og_q), .skip_q(skip_q),
    .dat_q(dat_o), .oe_q(dat_oe), .wr_q(wr_stb), .jump_q(jump_pulse),
    .ret_q(ret_pulse), .nlo_q(nop_lo_pulse), .nhi_q(nop_hi_pulse)
  );

  // Event lines visible to the assertions.
  logic ev_any_pulse, ev_flow_exec;
  assign ev_any_pulse = jump_pulse | ret_pulse | nop_lo_pulse | nop_hi_pulse | wr_stb;
  assign ev_flow_exec = ctl.jump | ctl.ret | ctl.nop_lo | ctl.nop_hi | ctl.skz | ctl.put;

  assert_single_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({jump_pulse, ret_pulse, nop_lo_pulse, nop_hi_pulse, wr_stb}));
  assert_skip_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |=> !ev_any_pulse && $stable(acc_o));
  assert_flow_keeps_acc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_flow_exec) |-> acc_o == $past(acc_o));
  assert_ret_arms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_pulse |-> skip_q);
endmodule

// File: tb/bitctl_core_test.sv
module bitctl_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_i = 4'h0;
  logic       dat_i = 1'b0;
  logic acc_o, dat_o, dat_oe, wr_stb, jump_pulse, ret_pulse, nop_lo_pulse, nop_hi_pulse;

  int n_run = 0;
  int n_fail = 0;

  // Reference state
  logic m_acc = 1'b0, m_ig = 1'b0, m_og = 1'b0, m_skip = 1'b0;

  always #4 clk = ~clk;

  bitctl_core uut (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .dat_i(dat_i), .acc_o(acc_o),
    .dat_o(dat_o), .dat_oe(dat_oe), .wr_stb(wr_stb), .jump_pulse(jump_pulse),
    .ret_pulse(ret_pulse), .nop_lo_pulse(nop_lo_pulse), .nop_hi_pulse(nop_hi_pulse)
  );

  function automatic logic [7:0] observed();
    return {acc_o, dat_o, dat_oe, wr_stb, jump_pulse, ret_pulse, nop_lo_pulse, nop_hi_pulse};
  endfunction

  task automatic check(input logic [7:0] exp, input string tag);
    n_run++;
    if (observed() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (acc,do,oe,wr,jmp,ret,nlo,nhi)", tag, observed(), exp);
    end
  endtask

  // Execute one opcode and compare every output against the reference model.
  task automatic exec(input logic [3:0] op, input logic d);
    logic de;
    logic e_do, e_oe, e_wr, e_j, e_r, e_lo, e_hi;
    string tag;
    int a, b;
    @(negedge clk);
    op_i = op; dat_i = d;
    de = d & m_ig;
    {e_do, e_oe, e_wr, e_j, e_r, e_lo, e_hi} = '0;
    a = int'(m_acc); b = int'(de);
    if (m_skip) begin
      m_skip = 1'b0; tag = "R11";
    end else begin
      tag = "R2";
      case (op)
        4'h0: begin e_lo = 1; tag = "R8"; end
        4'h1: m_acc = (b == 1);
        4'h2: m_acc = (b == 0);
        4'h3: begin m_acc = (a * b == 1); tag = "R3"; end
        4'h4: begin m_acc = (a * (1 - b) == 1); tag = "R3"; end
        4'h5: begin m_acc = (a + b > 0); tag = "R3"; end
        4'h6: begin m_acc = (a + 1 - b > 0); tag = "R3"; end
        4'h7: begin m_acc = (a == b); tag = "R3"; end
        4'h8, 4'h9: begin
          tag = m_og ? "R5" : "R6";
          if (m_og) begin
            e_oe = 1; e_wr = 1;
            e_do = (op == 4'h8) ? m_acc : !m_acc;
          end
        end
        4'hA: begin m_ig = d; tag = "R7"; end
        4'hB: begin m_og = d; tag = "R7"; end
        4'hC: begin e_j = 1; tag = "R8"; end
        4'hD: begin e_r = 1; m_skip = 1'b1; tag = "R9"; end
        4'hE: begin m_skip = (a == 0); tag = "R10"; end
        default: begin e_hi = 1; tag = "R8"; end
      endcase
      if (op >= 4'h1 && op <= 4'h7 && !m_ig) tag = "R4";
    end
    @(posedge clk);
    #1;
    check({m_acc, e_do, e_oe, e_wr, e_j, e_r, e_lo, e_hi}, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; op_i = 4'h0; dat_i = 1'b0;
    m_acc = 0; m_ig = 0; m_og = 0; m_skip = 0;
    #1;
    check(8'h00, "R1");
    repeat (2) @(negedge clk);
    check(8'h00, "R1");
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #1500000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1: gates cleared by reset -> loadn of 1 gives 1, store has no strobe
    exec(4'h2, 1'b1);
    exec(4'h8, 1'b1);
    exec(4'hF, 1'b0);

    // Exhaustive sweep over gates, start accumulator, opcode and data.
    for (int ig = 0; ig < 2; ig++)
      for (int og = 0; og < 2; og++)
        for (int a0 = 0; a0 < 2; a0++)
          for (int op = 0; op < 16; op++)
            for (int d = 0; d < 2; d++) begin
              exec(4'hA, 1'b1);
              exec(4'h1, a0[0]);
              exec(4'hB, og[0]);
              exec(4'hA, ig[0]);
              exec(op[3:0], d[0]);
              exec(4'hF, 1'b0);   // reveals an armed skip (R9, R10, R11)
              exec(4'h0, 1'b0);
            end

    // R11: skipped return and skipped skip-if-zero have no effect.
    exec(4'hA, 1'b1); exec(4'h1, 1'b0);
    exec(4'hE, 1'b0); exec(4'hD, 1'b0); exec(4'h0, 1'b0);
    exec(4'hD, 1'b0); exec(4'hE, 1'b0); exec(4'hF, 1'b0);
    exec(4'hD, 1'b0); exec(4'h1, 1'b1); exec(4'h2, 1'b0);
    // R5: back-to-back stores, each with its own strobe.
    exec(4'hB, 1'b1); exec(4'h1, 1'b1);
    exec(4'h8, 1'b0); exec(4'h9, 1'b0); exec(4'h8, 1'b0);

    // R1: reset while a skip is pending clears it.
    exec(4'h1, 1'b0); exec(4'hE, 1'b0);
    do_reset();
    exec(4'hF, 1'b0);
    exec(4'h1, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule